// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block sits on a two-wire serial bus (a clock line and an open-drain data line) and gives an external bus master read and write access to a register file of 128 byte-wide locations held outside the block. The bus lines are brought into the system clock domain through two-flop synchronisers. All protocol decoding then runs on the system clock, which must be at least eight times faster than the bus clock.

A transaction opens with a START and carries the 7-bit device address plus a direction bit. When the direction is write, the next byte is a pointer byte: its low seven bits select the first register and its top bit turns on pointer auto-increment. Further write bytes go into the register file through a single-cycle write strobe. To read, the master sends the pointer byte and then a repeated START with the direction bit set. The slave then shifts register contents out, most significant bit first, until the master declines a byte. A STOP ends any transaction. When the address does not match, the slave leaves the data line released until the next START or STOP.

Top module: `i2c_regslave`

## Requirements
- R1: A falling data line while the clock line is high is a START; it always restarts the address phase, and a repeated START in mid-transaction keeps the register pointer set by the earlier pointer byte.
- R2: A rising data line while the clock line is high is a STOP; the slave returns to idle with the data line released, and a STOP in the middle of a byte writes nothing.
- R3: The slave pulls the data line low during the ninth clock of the address byte only when bits 7..1 of that byte equal the DEV_ADDR parameter; on a mismatch it does not drive the data line and ignores every byte up to the next START or STOP.
- R4: The byte after an address byte whose bit 0 is 0 is the pointer byte and is acknowledged; its bits 6..0 become the register pointer and its bit 7 enables auto-increment.
- R5: Each later byte of a write transaction, received most significant bit first, is acknowledged and produces exactly one single-cycle reg_we pulse with reg_wdata equal to the byte and reg_addr equal to the current pointer.
- R6: After an address byte whose bit 0 is 1, the slave shifts out reg_rdata for the current pointer, most significant bit first. A master ACK (data low in the ninth clock) makes it send the next byte; a master NACK makes it release the data line until the next START or STOP.
- R7: With auto-increment on, the pointer advances by one after every data byte and wraps from 127 to 0; with it off, every data byte of the transaction uses the same register.
- R8: sda_oe changes only while the clock line is low, and the slave releases the data line at the end of each acknowledge clock it drives.
- R9: After reset sda_oe and reg_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | 7 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data of the register at reg_addr |

## Verification
On every cycle the assertions check these points: sda_oe changes only while the synchronised clock line is low; the write strobe lasts one cycle and appears only in the write-acknowledge phase; START and STOP force the address phase and idle; the data line stays released while idle or ignoring. Other behaviours show only in the bench's transaction scenarios, which compare every bit read back and every register written against a behavioural model. These are the acknowledge decisions, pointer loading, auto-increment with wrap, the non-incrementing mode, the pointer kept across a repeated START, a read ended by NACK, and a STOP cut into a half-sent byte.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        slv_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_BITS-1:0] shreg;
        logic                 rw;
        logic                 mack;
        logic                 sda_oe;
        logic                 we;
        logic [BYTE_BITS-1:0] wdata;
    } slv_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prv;

    assign raw = {sda_i, scl_i};

    // one synchroniser chain per bus line, plus one extra stage holding the previous value
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;
        logic [STAGES:0] pipe_d;

        always_comb begin
            pipe_d = {pipe_q[STAGES-1:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign cur[g] = pipe_q[STAGES-1];
        assign prv[g] = pipe_q[STAGES];
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  =  cur[0] & ~prv[0];
    assign scl_fall  = ~cur[0] &  prv[0];
    assign start_det =  cur[0] &  prv[0] &  prv[1] & ~cur[1];
    assign stop_det  =  cur[0] &  prv[0] & ~prv[1] &  cur[1];

endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             load_inc,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic             auto_inc
);

    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic             inc_d, inc_q;

    always_comb begin
        ptr_d = ptr_q;
        inc_d = inc_q;
        if (load) begin
            ptr_d = load_val;
            inc_d = load_inc;
        end else if (adv && inc_q) begin
            ptr_d = ptr_q + 1'b1;   // natural wrap across the pointer space
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            inc_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            inc_q <= inc_d;
        end
    end

    assign ptr      = ptr_q;
    assign auto_inc = inc_q;

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);

    localparam int               PTR_W    = BYTE_BITS - 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_TAIL = CNT_W'(BYTE_BITS - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    logic             ptr_load, ptr_adv, auto_inc;
    logic [PTR_W-1:0] ptr;

    slv_regs_t r_d, r_q;

    i2c_reg_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (r_q.shreg[PTR_W-1:0]),
        .load_inc (r_q.shreg[BYTE_BITS-1]),
        .adv      (ptr_adv),
        .ptr      (ptr),
        .auto_inc (auto_inc)
    );

    slv_state_e cur_state;
    assign cur_state = r_q.state;

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        ptr_load = 1'b0;
        ptr_adv  = 1'b0;

        unique case (r_q.state)
            ST_ADDR, ST_SUB, ST_WDATA: begin
                if (scl_rise) begin
                    r_d.shreg = {r_q.shreg[BYTE_BITS-2:0], sda_s};
                    r_d.cnt   = r_q.cnt + 1'b1;
                end else if (scl_fall && r_q.cnt == CNT_LAST) begin
                    r_d.cnt = '0;
                    if (r_q.state == ST_ADDR) begin
                        if (r_q.shreg[BYTE_BITS-1:1] == DEV_ADDR) begin
                            r_d.state = ST_ADDR_ACK;
                            r_d.rw    = r_q.shreg[0];
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end else if (r_q.state == ST_SUB) begin
                        r_d.state = ST_SUB_ACK;
                        ptr_load  = 1'b1;
                    end else begin
                        r_d.state = ST_WDATA_ACK;
                        r_d.we    = 1'b1;
                        r_d.wdata = r_q.shreg;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall) begin
                    r_d.cnt = '0;
                    if (r_q.rw) begin
                        r_d.state = ST_RDATA;
                        r_d.shreg = reg_rdata;
                    end else begin
                        r_d.state = ST_SUB;
                    end
                end
            end
            ST_SUB_ACK: begin
                if (scl_fall) begin
                    r_d.state = ST_WDATA;
                    r_d.cnt   = '0;
                end
            end
            ST_WDATA_ACK: begin
                if (scl_fall) begin
                    r_d.state = ST_WDATA;
                    r_d.cnt   = '0;
                    ptr_adv   = 1'b1;
                end
            end
            ST_RDATA: begin
                if (scl_fall) begin
                    r_d.shreg = {r_q.shreg[BYTE_BITS-2:0], 1'b0};
                    r_d.cnt   = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_TAIL) begin
                        r_d.state = ST_RDATA_ACK;
                        ptr_adv   = 1'b1;   // next read data is fetched during the ack clock
                    end
                end
            end
            ST_RDATA_ACK: begin
                if (scl_rise) begin
                    r_d.mack = ~sda_s;
                end else if (scl_fall) begin
                    r_d.cnt = '0;
                    if (r_q.mack) begin
                        r_d.state = ST_RDATA;
                        r_d.shreg = reg_rdata;
                    end else begin
                        r_d.state = ST_IGNORE;
                    end
                end
            end
            default: ;
        endcase

        if (start_det) begin
            r_d.state = ST_ADDR;
            r_d.cnt   = '0;
        end else if (stop_det) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end

        unique case (r_d.state)
            ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: r_d.sda_oe = 1'b1;
            ST_RDATA:                              r_d.sda_oe = ~r_d.shreg[BYTE_BITS-1];
            default:                               r_d.sda_oe = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, rw: 1'b0, mack: 1'b0,
                     sda_oe: 1'b0, we: 1'b0, wdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.sda_oe;
    assign reg_we    = r_q.we;
    assign reg_wdata = r_q.wdata;
    assign reg_addr  = ptr;

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk
    import i2c_regslave_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_we,
    input logic       start_det,
    input logic       stop_det,
    input slv_state_e cur_state
);

    // R8: the data line driver only toggles while the clock line is low
    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R5: a write strobe lasts a single cycle
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: a write strobe only accompanies the acknowledge of a data byte
    p_we_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> cur_state == ST_WDATA_ACK);

    // R1: a start condition always leads into the address phase
    p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> cur_state == ST_ADDR);

    // R2: a stop condition always leads to idle
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> cur_state == ST_IDLE);

    // R2: idle leaves the data line released
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_IDLE |-> !sda_oe);

    // R3: an unaddressed or finished slave keeps off the bus
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == ST_IGNORE |-> !sda_oe);

endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .start_det (start_det),
    .stop_det  (stop_det),
    .cur_state (cur_state)
);

// File: tb/sim_i2c_regslave.sv
`timescale 1ns/1ps
module sim_i2c_regslave;

    localparam logic [6:0] ADDR = 7'h2A;
    localparam int         Q    = 100;   // quarter of a bus clock period, in ns

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;

    always #5 clk = ~clk;

    assign sda_line = sda_oe ? 1'b0 : m_sda;

    i2c_regslave #(.DEV_ADDR(ADDR)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    // external register file seen by the slave
    logic [7:0] rf [128];
    assign reg_rdata = rf[reg_addr];
    always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

    // behavioural expectation of the register file
    logic [7:0] exp_rf [128];

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit  foreign = 1'b0;
    int  oe_glitch = 0;
    int  foreign_drive = 0;
    int  we_count = 0;
    logic prev_oe = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe != prev_oe && scl) oe_glitch++;
            if (foreign && sda_oe)        foreign_drive++;
            if (reg_we)                   we_count++;
        end
        prev_oe = sda_oe;
    end

    task automatic bit_io(input logic b, output logic r);
        m_sda = b;
        #Q; scl = 1'b1;
        #Q; r = sda_line;
        #Q; scl = 1'b0;
        #Q;
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        #Q; scl = 1'b1;
        #Q; m_sda = 1'b0;
        #Q; scl = 1'b0;
        #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        #Q; scl = 1'b1;
        #Q; m_sda = 1'b1;
        #(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, r);
        acked = (r == 1'b0);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(mack ? 1'b0 : 1'b1, r);
    endtask

    task automatic write_regs(input logic [7:0] sub, input logic [7:0] data [$], input string req);
        bit ack;
        logic [6:0] p;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R3 address ack", ack, 1);
        send_byte(sub, ack);
        check(ack, "R4 pointer ack", ack, 1);
        p = sub[6:0];
        foreach (data[i]) begin
            send_byte(data[i], ack);
            check(ack, {req, " data ack"}, ack, 1);
            exp_rf[p] = data[i];
            if (sub[7]) p = p + 1'b1;
        end
        bus_stop();
    endtask

    task automatic read_regs(input logic [7:0] sub, input int n, input string req);
        bit ack;
        logic [6:0] p;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(ack, "R3 address ack", ack, 1);
        send_byte(sub, ack);
        check(ack, "R4 pointer ack", ack, 1);
        bus_start();   // repeated start keeps the pointer (R1)
        send_byte({ADDR, 1'b1}, ack);
        check(ack, "R1 address ack after repeated start", ack, 1);
        p = sub[6:0];
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check(d == exp_rf[p], {req, " read data"}, d, exp_rf[p]);
            if (sub[7]) p = p + 1'b1;
        end
        #Q;
        check(sda_oe == 1'b0, "R6 release after master NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic compare_rf(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 128; i++) begin
            if (rf[i] !== exp_rf[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, {req, " register file"}, bad, 0);
        if (bad != 0) $display("  first mismatch at %0h: %0h vs %0h", first, rf[first], exp_rf[first]);
    endtask

    initial begin
        logic [7:0] q [$];
        bit ack;
        logic r;
        int we_before;

        for (int i = 0; i < 128; i++) begin
            rf[i]     = 8'(i * 3 + 1);
            exp_rf[i] = 8'(i * 3 + 1);
        end

        repeat (5) @(posedge clk);
        #1;
        check(sda_oe == 1'b0 && reg_we == 1'b0, "R9 reset outputs", {sda_oe, reg_we}, 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R5: single write, one strobe
        we_before = we_count;
        q = '{8'hA5};
        write_regs(8'h05, q, "R5");
        compare_rf("R5 single write");
        check(we_count - we_before == 1, "R5 one strobe per byte", we_count - we_before, 1);
        check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);

        // R7: auto-increment burst with wrap
        we_before = we_count;
        q = '{8'h11, 8'h22, 8'h33};
        write_regs(8'hFE, q, "R7");
        compare_rf("R7 increment wrap write");
        check(we_count - we_before == 3, "R5 burst strobe count", we_count - we_before, 3);

        // R7: no increment, all bytes to one register
        q = '{8'h44, 8'h55};
        write_regs(8'h10, q, "R7");
        compare_rf("R7 fixed pointer write");

        // R6: reads
        read_regs(8'h05, 1, "R6 single");
        read_regs(8'hFE, 3, "R7 increment wrap");
        read_regs(8'h10, 2, "R7 fixed pointer");
        read_regs(8'hC0, 4, "R6 burst");

        // R3: foreign address, remaining bytes ignored
        we_before = we_count;
        bus_start();
        foreign = 1'b1;
        send_byte({7'h2B, 1'b0}, ack);
        check(!ack, "R3 no ack for foreign address", ack, 0);
        send_byte(8'h05, ack);
        check(!ack, "R3 ignored pointer byte", ack, 0);
        send_byte(8'h00, ack);
        check(!ack, "R3 ignored data byte", ack, 0);
        foreign = 1'b0;
        bus_stop();
        check(we_count == we_before, "R3 no write for foreign address", we_count - we_before, 0);
        check(foreign_drive == 0, "R3 data line never driven", foreign_drive, 0);
        compare_rf("R3 foreign transaction");

        // R2: stop in the middle of a data byte writes nothing
        we_before = we_count;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h20, ack);
        check(ack, "R4 pointer ack before abort", ack, 1);
        for (int i = 0; i < 3; i++) bit_io(1'b1, r);
        bus_stop();
        check(we_count == we_before, "R2 aborted byte not written", we_count - we_before, 0);
        compare_rf("R2 abort");
        q = '{8'h9C};
        write_regs(8'h20, q, "R2 after abort");
        compare_rf("R2 recovery write");

        check(oe_glitch == 0, "R8 data drive changes with clock low", oe_glitch, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule